// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block takes a three-wire serial programming stream (a serial clock, a serial data line and a latch-enable) and turns it into the static control fields of a frequency synthesizer. Bits are shifted, most significant first, into a 22-bit word. When latch-enable rises, the two lowest bits of that word are decoded as an address. The upper bits are then copied into one of three control registers, and each register has its own fixed field layout.

All three serial lines come from outside and are sampled in one system clock domain. Each line passes through a two-flop synchronizer. The serial clock and latch-enable are also edge-detected, so all state changes on system clock edges. The decoded fields are driven as registered outputs. Each accepted load raises a one-cycle strobe for the register that was written, so that downstream logic, for example a timeout counter, can restart itself. The three-bit output-select field is assembled from two registers: its two low bits come from the reference register and its top bit from the timeout register.

Top module: `serial_cfg_loader`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_dat` into the LSB of a 22-bit word, with the existing bits moving toward the MSB. Only the last 22 bits shifted before a latch count; earlier bits are lost.
- R2: On a rising edge of `ser_le`, word bits 1:0 select the target register: 0 is the reference register, 1 the counter register and 2 the timeout register.
- R3: A reference-register load sets `ref_count` from bits 16:2, `pd_pol` from bit 17, `cp_x4` from bit 18, `cp_tri` from bit 19, `osel[0]` from bit 20 and `osel[1]` from bit 21.
- R4: A counter-register load sets `a_count` from bits 6:2, `b_count` from bits 19:7, `presc_sel` from bit 20 and `pwr_dn` from bit 21.
- R5: A timeout-register load sets `tmo_count` from bits 13:2 and `osel[2]` from bit 14, and leaves `osel[1:0]` unchanged.
- R6: A latch with address 3 changes no output and raises no strobe.
- R7: Every accepted load raises exactly one of `wr_ref`, `wr_cnt` or `wr_tmo`, for one system clock cycle, in the same cycle that the new field values first appear.
- R8: A reference-register load whose bits 16:2 hold 0 or 1 sets `ref_count` to 2. Values from 2 to 32767 load unchanged.
- R9: Loads work normally while `pwr_dn` is 1, and that includes a counter-register load that clears `pwr_dn`.
- R10: After `rst`, every output is zero.
- R11: Shifting bits without a rising edge on `ser_le` changes no output and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first, asynchronous |
| ser_le | input | 1 | Latch-enable, rising edge loads, asynchronous |
| ref_count | output | 15 | Reference divider count |
| pd_pol | output | 1 | Phase detector polarity |
| cp_x4 | output | 1 | Charge pump 4x current select |
| cp_tri | output | 1 | Charge pump tristate |
| osel | output | 3 | Output-select field (bit 2 from timeout register) |
| a_count | output | 5 | Swallow (A) count |
| b_count | output | 13 | Main (B) count |
| presc_sel | output | 1 | Prescaler modulus select |
| pwr_dn | output | 1 | Power-down request |
| tmo_count | output | 12 | Timeout count |
| wr_ref | output | 1 | One-cycle strobe, reference register written |
| wr_cnt | output | 1 | One-cycle strobe, counter register written |
| wr_tmo | output | 1 | One-cycle strobe, timeout register written |

## Verification
A serial line that changes between clock edges is seen in the synchronizer's second flop two system edges later. The edge is detected during the following cycle, so the shift or load takes effect on the third edge. The new fields and the strobe become visible together right after that edge. The bench therefore holds data stable for three cycles on each side of a serial-clock rise, and keeps latch-enable high for three cycles. It checks the fields four cycles after latch-enable falls, well after the load. It counts strobes at every edge and compares the number raised per load, rather than sampling a single cycle.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int ADDR_W = 2;
  localparam int REF_W  = 15;
  localparam int A_W    = 5;
  localparam int B_W    = 13;
  localparam int TMO_W  = 12;
  localparam int WORD_W = 22;
  localparam int N_REGS = 3;
  localparam int OSEL_W = 3;
  localparam int REF_MIN = 2;

  typedef enum logic [ADDR_W-1:0] {
    TGT_REF  = 2'd0,
    TGT_CNT  = 2'd1,
    TGT_TMO  = 2'd2,
    TGT_NONE = 2'd3
  } tgt_e;

  typedef struct packed {
    logic [REF_W-1:0] count;
    logic             pol;
    logic             x4;
    logic             tri_st;
    logic [1:0]       osel_lo;
  } ref_fields_t;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           presc;
    logic           pdn;
  } cnt_fields_t;

  typedef struct packed {
    logic [TMO_W-1:0] count;
    logic             osel_hi;
  } tmo_fields_t;
endpackage

// File: rtl/cfg_bit_sync.sv
module cfg_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '0;
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cfg_rise_det.sv
module cfg_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/cfg_shift_word.sv
module cfg_shift_word #(
  parameter int W = 22
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[W-2:0], bit_in};
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import serial_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output ref_fields_t       ref_q,
  output cnt_fields_t       cnt_q,
  output tmo_fields_t       tmo_q,
  output logic [N_REGS-1:0] wr_q
);
  localparam int REF_LSB = ADDR_W;
  localparam int REF_MSB = REF_LSB + REF_W - 1;
  localparam int POL_BIT = REF_MSB + 1;
  localparam int X4_BIT  = POL_BIT + 1;
  localparam int TRI_BIT = X4_BIT + 1;
  localparam int OS0_BIT = TRI_BIT + 1;
  localparam int OS1_BIT = OS0_BIT + 1;

  localparam int A_LSB   = ADDR_W;
  localparam int A_MSB   = A_LSB + A_W - 1;
  localparam int B_LSB   = A_MSB + 1;
  localparam int B_MSB   = B_LSB + B_W - 1;
  localparam int PRE_BIT = B_MSB + 1;
  localparam int PDN_BIT = PRE_BIT + 1;

  localparam int T_LSB   = ADDR_W;
  localparam int T_MSB   = T_LSB + TMO_W - 1;
  localparam int OS2_BIT = T_MSB + 1;

  logic [ADDR_W-1:0] addr;
  logic [REF_W-1:0]  ref_raw;
  logic [REF_W-1:0]  ref_legal;

  assign addr    = word[ADDR_W-1:0];
  assign ref_raw = word[REF_MSB:REF_LSB];

  always_comb begin
    if (ref_raw < REF_W'(REF_MIN)) ref_legal = REF_W'(REF_MIN);
    else                           ref_legal = ref_raw;
  end

  genvar g;
  generate
    for (g = 0; g < N_REGS; g++) begin : g_strobe
      always_ff @(posedge clk) begin
        if (rst) wr_q[g] <= 1'b0;
        else     wr_q[g] <= load && (addr == ADDR_W'(g));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
    end else if (load && addr == TGT_REF) begin
      ref_q.count   <= ref_legal;
      ref_q.pol     <= word[POL_BIT];
      ref_q.x4      <= word[X4_BIT];
      ref_q.tri_st  <= word[TRI_BIT];
      ref_q.osel_lo <= {word[OS1_BIT], word[OS0_BIT]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load && addr == TGT_CNT) begin
      cnt_q.a     <= word[A_MSB:A_LSB];
      cnt_q.b     <= word[B_MSB:B_LSB];
      cnt_q.presc <= word[PRE_BIT];
      cnt_q.pdn   <= word[PDN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_q <= '0;
    end else if (load && addr == TGT_TMO) begin
      tmo_q.count   <= word[T_MSB:T_LSB];
      tmo_q.osel_hi <= word[OS2_BIT];
    end
  end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_le,
  output logic [REF_W-1:0] ref_count,
  output logic             pd_pol,
  output logic             cp_x4,
  output logic             cp_tri,
  output logic [OSEL_W-1:0] osel,
  output logic [A_W-1:0]   a_count,
  output logic [B_W-1:0]   b_count,
  output logic             presc_sel,
  output logic             pwr_dn,
  output logic [TMO_W-1:0] tmo_count,
  output logic             wr_ref,
  output logic             wr_cnt,
  output logic             wr_tmo
);
  logic sclk_s, sdat_s, sle_s;
  logic sclk_rise, sle_rise;
  logic [WORD_W-1:0] word;
  ref_fields_t ref_q;
  cnt_fields_t cnt_q;
  tmo_fields_t tmo_q;
  logic [N_REGS-1:0] wr_q;

  cfg_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst(rst), .din(ser_clk), .dout(sclk_s));
  cfg_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
    .clk(clk), .rst(rst), .din(ser_dat), .dout(sdat_s));
  cfg_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_le (
    .clk(clk), .rst(rst), .din(ser_le), .dout(sle_s));

  cfg_rise_det u_rise_clk (.clk(clk), .rst(rst), .lvl(sclk_s), .rise(sclk_rise));
  cfg_rise_det u_rise_le  (.clk(clk), .rst(rst), .lvl(sle_s),  .rise(sle_rise));

  cfg_shift_word #(.W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(sclk_rise), .bit_in(sdat_s), .word(word));

  cfg_reg_bank u_bank (
    .clk(clk), .rst(rst), .load(sle_rise), .word(word),
    .ref_q(ref_q), .cnt_q(cnt_q), .tmo_q(tmo_q), .wr_q(wr_q));

  assign ref_count = ref_q.count;
  assign pd_pol    = ref_q.pol;
  assign cp_x4     = ref_q.x4;
  assign cp_tri    = ref_q.tri_st;
  assign osel      = {tmo_q.osel_hi, ref_q.osel_lo};
  assign a_count   = cnt_q.a;
  assign b_count   = cnt_q.b;
  assign presc_sel = cnt_q.presc;
  assign pwr_dn    = cnt_q.pdn;
  assign tmo_count = tmo_q.count;
  assign wr_ref    = wr_q[TGT_REF];
  assign wr_cnt    = wr_q[TGT_CNT];
  assign wr_tmo    = wr_q[TGT_TMO];
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk
  import serial_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [REF_W-1:0] ref_count,
  input logic             pd_pol,
  input logic             cp_x4,
  input logic             cp_tri,
  input logic [OSEL_W-1:0] osel,
  input logic [A_W-1:0]   a_count,
  input logic [B_W-1:0]   b_count,
  input logic             presc_sel,
  input logic             pwr_dn,
  input logic [TMO_W-1:0] tmo_count,
  input logic             wr_ref,
  input logic             wr_cnt,
  input logic             wr_tmo
);
  // R7: at most one strobe at a time
  p_strobe_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_ref, wr_cnt, wr_tmo}));

  // R7: strobes last one cycle
  p_strobe_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_ref || wr_cnt || wr_tmo) |=> !(wr_ref || wr_cnt || wr_tmo));

  // R8: a reference load never leaves a count below 2
  p_ref_min_r8: assert property (@(posedge clk) disable iff (rst)
    wr_ref |-> (ref_count >= REF_W'(REF_MIN)));

  // R3: reference fields move only with their strobe
  p_ref_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_ref |-> ($stable(ref_count) && $stable(pd_pol) && $stable(cp_x4)
                 && $stable(cp_tri) && $stable(osel[1:0])));

  // R4: counter fields move only with their strobe
  p_cnt_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !wr_cnt |-> ($stable(a_count) && $stable(b_count) && $stable(presc_sel)
                 && $stable(pwr_dn)));

  // R5: timeout fields move only with their strobe
  p_tmo_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_tmo |-> ($stable(tmo_count) && $stable(osel[2])));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (.*);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
  logic [14:0] ref_count;
  logic pd_pol, cp_x4, cp_tri, presc_sel, pwr_dn;
  logic [2:0] osel;
  logic [4:0] a_count;
  logic [12:0] b_count;
  logic [11:0] tmo_count;
  logic wr_ref, wr_cnt, wr_tmo;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int n_ref = 0, n_cnt = 0, n_tmo = 0;
  bit done = 0;

  // expected state
  logic [14:0] e_ref;  logic e_pol, e_x4, e_tri;
  logic [2:0] e_osel;  logic [4:0] e_a; logic [12:0] e_b;
  logic e_pre, e_pdn;  logic [11:0] e_tmo;

  serial_cfg_loader uut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
    .ref_count(ref_count), .pd_pol(pd_pol), .cp_x4(cp_x4), .cp_tri(cp_tri),
    .osel(osel), .a_count(a_count), .b_count(b_count), .presc_sel(presc_sel),
    .pwr_dn(pwr_dn), .tmo_count(tmo_count),
    .wr_ref(wr_ref), .wr_cnt(wr_cnt), .wr_tmo(wr_tmo));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (!rst) begin
      if (wr_ref) n_ref++;
      if (wr_cnt) n_cnt++;
      if (wr_tmo) n_tmo++;
    end
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [21:0] mk_ref(input logic [14:0] c, input logic pol,
      input logic x4, input logic tr, input logic o0, input logic o1);
    return {o1, o0, tr, x4, pol, c, 2'd0};
  endfunction

  function automatic logic [21:0] mk_cnt(input logic [4:0] a, input logic [12:0] b,
      input logic pre, input logic pdn);
    return {pdn, pre, b, a, 2'd1};
  endfunction

  function automatic logic [21:0] mk_tmo(input logic [11:0] t, input logic o2);
    return {7'd0, o2, t, 2'd2};
  endfunction

  task automatic model(input logic [21:0] w);
    case (w[1:0])
      2'd0: begin
        e_ref = (w[16:2] < 15'd2) ? 15'd2 : w[16:2];
        e_pol = w[17]; e_x4 = w[18]; e_tri = w[19];
        e_osel[0] = w[20]; e_osel[1] = w[21];
      end
      2'd1: begin
        e_a = w[6:2]; e_b = w[19:7]; e_pre = w[20]; e_pdn = w[21];
      end
      2'd2: begin
        e_tmo = w[13:2]; e_osel[2] = w[14];
      end
      default: ;
    endcase
  endtask

  task automatic sbit(input logic b);
    @(negedge clk) ser_dat = b;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (3) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic shift_word(input logic [21:0] w);
    for (int i = 21; i >= 0; i--) sbit(w[i]);
  endtask

  task automatic latch();
    @(negedge clk) ser_le = 1'b1;
    repeat (3) @(negedge clk);
    ser_le = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    chk({tag, " ref_count"}, ref_count, e_ref);
    chk({tag, " pd_pol"}, pd_pol, e_pol);
    chk({tag, " cp_x4"}, cp_x4, e_x4);
    chk({tag, " cp_tri"}, cp_tri, e_tri);
    chk({tag, " osel"}, osel, e_osel);
    chk({tag, " a_count"}, a_count, e_a);
    chk({tag, " b_count"}, b_count, e_b);
    chk({tag, " presc_sel"}, presc_sel, e_pre);
    chk({tag, " pwr_dn"}, pwr_dn, e_pdn);
    chk({tag, " tmo_count"}, tmo_count, e_tmo);
  endtask

  // shift, latch, update model and compare fields and strobe counts (R7)
  task automatic send(input string tag, input logic [21:0] w);
    int r0, c0, t0;
    r0 = n_ref; c0 = n_cnt; t0 = n_tmo;
    shift_word(w);
    latch();
    model(w);
    check_all(tag);
    chk({tag, " R7 wr_ref count"}, n_ref - r0, (w[1:0] == 2'd0) ? 1 : 0);
    chk({tag, " R7 wr_cnt count"}, n_cnt - c0, (w[1:0] == 2'd1) ? 1 : 0);
    chk({tag, " R7 wr_tmo count"}, n_tmo - t0, (w[1:0] == 2'd2) ? 1 : 0);
  endtask

  initial begin
    logic [21:0] w;
    void'($urandom(32'h1234_5678));
    e_ref = '0; e_pol = 0; e_x4 = 0; e_tri = 0; e_osel = '0;
    e_a = '0; e_b = '0; e_pre = 0; e_pdn = 0; e_tmo = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_all("R10 reset");

    send("R3 R2 ref", mk_ref(15'h1234, 1, 0, 1, 1, 0));
    send("R4 R2 cnt", mk_cnt(5'h15, 13'h0ABC, 1, 0));
    send("R5 R2 tmo", mk_tmo(12'hA5F, 1));
    chk("R5 osel split", osel, 3'b101);
    send("R3 ref walk", mk_ref(15'h4B2D, 0, 1, 0, 0, 1));
    chk("R5 osel hi kept", osel, 3'b110);
    send("R5 tmo clear", mk_tmo(12'h001, 0));

    send("R8 ref zero", mk_ref(15'd0, 1, 1, 1, 1, 1));
    chk("R8 clamp0", ref_count, 15'd2);
    send("R8 ref one", mk_ref(15'd1, 0, 0, 0, 0, 0));
    chk("R8 clamp1", ref_count, 15'd2);
    send("R8 ref two", mk_ref(15'd2, 0, 0, 0, 0, 0));
    send("R8 ref max", mk_ref(15'h7FFF, 1, 0, 0, 1, 0));

    send("R6 addr3", 22'h3FFFFF);
    send("R6 addr3b", 22'h15A5A7);

    send("R9 power down", mk_cnt(5'h03, 13'h1FFF, 0, 1));
    send("R9 ref while down", mk_ref(15'h0777, 1, 1, 0, 0, 1));
    send("R9 tmo while down", mk_tmo(12'h800, 1));
    send("R9 wake", mk_cnt(5'h1F, 13'h0001, 1, 0));

    // R11: shift without latch leaves outputs alone
    begin
      int r0, c0, t0;
      r0 = n_ref; c0 = n_cnt; t0 = n_tmo;
      w = mk_tmo(12'h3C3, 0);
      shift_word(w);
      repeat (6) @(negedge clk);
      check_all("R11 no latch");
      chk("R11 no strobe", (n_ref - r0) + (n_cnt - c0) + (n_tmo - t0), 0);
      latch();
      model(w);
      check_all("R11 late latch");
    end

    // R1: extra leading bits are pushed out
    sbit(1'b1); sbit(1'b0); sbit(1'b1);
    send("R1 overlong", mk_cnt(5'h0A, 13'h1555, 0, 0));

    for (int k = 0; k < 30; k++) begin
      w = 22'($urandom());
      if (k % 7 == 0) w[16:2] = 15'($urandom_range(0, 1));
      send("R1 random", w);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule